// File: doc/BRIEF.md
# Register-Mapped Serial FRAM Access Controller

This block sits on a host byte I/O port and gives software four byte-wide registers through which a 32 KB serial ferroelectric memory on an SPI link can be read and written. Software loads a 15-bit memory address into two address registers. An access to the data register then makes the block run the whole SPI command sequence on its own. Software never handles opcodes, chip select or bit timing.

A data write is posted. The host side completes at once, and the SPI side sends a write-enable frame and then a write frame. A data read holds the host with a wait until the byte has been shifted in, and the byte comes back at the end of that wait. A burst mode advances the address after every data access, so software can stream through the array without reloading the address. A lock input guards the top kilobyte of the array against writes. The lock state and a busy flag can be read from the control/status register.

The host protocol works as follows. The host holds `hst_req` with address, direction and write data until it sees `hst_ready` high for one cycle. Read data is valid in that same cycle. Requests to addresses outside the four-byte window get no answer. `BASE_ADDR` must be a multiple of 4.

Top module: `fram_host_ctrl`

## Requirements
- R1: After reset, offsets 0, 1, 2 and 3 hold 00h. A status read (offset 3) returns {busy in bit 7, lock pin in bit 6, bits 5:1 zero, burst enable in bit 0}. With the lock pin low and nothing pending, it reads 00h.
- R2: The block answers only host addresses BASE_ADDR to BASE_ADDR+3. Any other address gets no `hst_ready`, and a write there changes no register. Each answered access gets exactly one single-cycle `hst_ready`.
- R3: The address is 15 bits. Offset 0 holds bits 7:0 and offset 1 holds bits 14:8. Bit 7 of offset 1 is not stored and reads as 0.
- R4: Writing offset 2 produces two SPI frames. The first is a frame holding only opcode 06h. The second holds opcode 02h, then the address high byte (top bit 0), then the address low byte, then the data byte. All bytes are sent MSB first. The host write completes without waiting for the SPI traffic.
- R5: Reading offset 2 produces one frame: opcode 03h, address high byte, address low byte, then eight bits shifted in from MISO. `hst_ready` is withheld until that byte arrives, and `hst_rdata` then carries it.
- R6: Status bit 7 reads 1 while an SPI transaction or its trailing chip-select gap is pending. A data access made while busy is held and then carried out in order.
- R7: Writes to offsets 0 and 1 while busy are ignored.
- R8: With burst enable (offset 3 bit 0) set, the address increments by one after every offset-2 read or write. It wraps from 7FFFh to 0000h. With burst enable clear, the address does not change.
- R9: With the lock pin high, an offset-2 write whose address lies in 7C00h–7FFFh produces no SPI frame and leaves memory unchanged. Burst increment still takes place. Reads and writes below 7C00h are unaffected.
- R10: Only bit 0 of offset 3 is writable. Writing FFh there reads back as 01h, ORed with the lock bit.
- R11: SPI runs in mode 0. SCK idles low whenever chip select is high. Successive SCK rising edges within a frame are exactly SCK_DIV clocks apart. Chip select stays high for at least SCK_DIV clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access request, held until `hst_ready` |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 16 | Host I/O address |
| hst_wdata | input | 8 | Host write data |
| hst_ready | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 8 | Read data, valid with `hst_ready` |
| lock_top | input | 1 | Write lock for addresses 7C00h–7FFFh |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to memory |
| spi_miso | input | 1 | SPI data from memory |

## Verification
The bench targets the address wrap at 7FFFh under burst mode. A design without the wrap would land the third byte of a burst at a wrong location or read back a nonzero high address. It also targets locked writes on both sides of the 7C00h boundary, where an off-by-one decode either blocks a legal write at 7BFFh or lets a frame through at 7C00h. A further check writes the address registers while a posted write is still draining; a design that accepts such writes shows a changed address on readback. The behavioural memory also counts writes that arrive without a preceding write-enable, frames with a partial byte, uneven SCK spacing and chip-select gaps shorter than one SCK period. These catch sequencing and timing slips that a simple data compare would miss.

// File: rtl/fram_pkg.sv
package fram_pkg;

    localparam int FRAM_AW = 15;
    localparam int FRAM_DW = 8;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;

    localparam logic [FRAM_AW-1:0] LOCK_FIRST = 15'h7C00;

    typedef enum logic [1:0] {
        FR_WREN  = 2'd0,
        FR_WRITE = 2'd1,
        FR_READ  = 2'd2
    } frame_e;

    typedef enum logic [1:0] {
        OFF_ALO  = 2'd0,
        OFF_AHI  = 2'd1,
        OFF_DATA = 2'd2,
        OFF_CTRL = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic               write;
        logic [FRAM_AW-1:0] addr;
        logic [FRAM_DW-1:0] data;
    } fram_cmd_t;

    function automatic logic [1:0] frame_last(frame_e k);
        return (k == FR_WREN) ? 2'd0 : 2'd3;
    endfunction

    function automatic logic in_locked_kb(logic [FRAM_AW-1:0] a);
        return a >= LOCK_FIRST;
    endfunction

    function automatic logic [7:0] frame_byte(frame_e k, logic [1:0] idx,
                                              logic [FRAM_AW-1:0] a,
                                              logic [FRAM_DW-1:0] d);
        logic [7:0] b;
        case (idx)
            2'd0: begin
                case (k)
                    FR_WREN:  b = OP_WREN;
                    FR_WRITE: b = OP_WRITE;
                    default:  b = OP_READ;
                endcase
            end
            2'd1:    b = {1'b0, a[14:8]};
            2'd2:    b = a[7:0];
            default: b = (k == FR_WRITE) ? d : 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fram_spi_byte.sv
module fram_spi_byte
    import fram_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    localparam int HALF = SCK_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic          sck_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic [2:0]    bit_q;
    logic [HW-1:0] hcnt;
    logic          tick;

    assign tick = (hcnt == HW'(HALF - 1));
    assign done = active && tick && sck_q && (bit_q == 3'd7);
    assign rx   = rx_q;
    assign sck  = sck_q;
    assign mosi = sh_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sck_q  <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            hcnt   <= '0;
        end else if (start) begin
            active <= 1'b1;
            sck_q  <= 1'b0;
            sh_q   <= tx;
            bit_q  <= '0;
            hcnt   <= '0;
        end else if (active) begin
            if (tick) begin
                hcnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    sh_q  <= {sh_q[6:0], 1'b0};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) active <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    // R11: the clock is never left high once the shifter has gone idle
    a_r11_idle_sck_low: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sck_q);

endmodule

// File: rtl/fram_spi_seq.sv
module fram_spi_seq
    import fram_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_vld,
    input  fram_cmd_t          cmd,
    output logic               busy,
    output logic               rd_done,
    output logic [FRAM_DW-1:0] rd_byte,
    output logic               spi_cs_n,
    output logic               byte_start,
    output logic [7:0]         byte_tx,
    input  logic               byte_done,
    input  logic [7:0]         byte_rx
);

    localparam int HALF = SCK_DIV / 2;
    localparam int CW   = $clog2(SCK_DIV) + 1;

    typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP} seq_st_e;

    seq_st_e            st;
    frame_e             kind;
    logic [1:0]         idx;
    logic [1:0]         nidx;
    logic [CW-1:0]      cnt;
    logic               then_write;
    logic [FRAM_AW-1:0] addr_q;
    logic [FRAM_DW-1:0] data_q;
    logic               cs_q;

    assign busy     = (st != S_IDLE);
    assign spi_cs_n = cs_q;

    always_comb begin
        byte_start = 1'b0;
        nidx       = idx;
        if (st == S_LEAD && cnt == CW'(HALF - 1)) begin
            byte_start = 1'b1;
            nidx       = 2'd0;
        end else if (st == S_SHIFT && byte_done && idx != frame_last(kind)) begin
            byte_start = 1'b1;
            nidx       = idx + 2'd1;
        end
        byte_tx = frame_byte(kind, nidx, addr_q, data_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            kind       <= FR_WREN;
            idx        <= '0;
            cnt        <= '0;
            then_write <= 1'b0;
            addr_q     <= '0;
            data_q     <= '0;
            cs_q       <= 1'b1;
            rd_done    <= 1'b0;
            rd_byte    <= '0;
        end else begin
            rd_done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (cmd_vld) begin
                        addr_q     <= cmd.addr;
                        data_q     <= cmd.data;
                        kind       <= cmd.write ? FR_WREN : FR_READ;
                        then_write <= cmd.write;
                        cnt        <= '0;
                        cs_q       <= 1'b0;
                        st         <= S_LEAD;
                    end
                end
                S_LEAD: begin
                    cnt <= cnt + CW'(1);
                    if (byte_start) begin
                        idx <= nidx;
                        st  <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (byte_done) begin
                        if (idx == frame_last(kind)) begin
                            cs_q <= 1'b1;
                            cnt  <= '0;
                            st   <= S_GAP;
                            if (kind == FR_READ) begin
                                rd_done <= 1'b1;
                                rd_byte <= byte_rx;
                            end
                        end else begin
                            idx <= nidx;
                        end
                    end
                end
                default: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(SCK_DIV - 1)) begin
                        if (then_write) begin
                            then_write <= 1'b0;
                            kind       <= FR_WRITE;
                            cnt        <= '0;
                            cs_q       <= 1'b0;
                            st         <= S_LEAD;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R6: chip select is only ever active while the sequencer reports busy
    a_r6_cs_means_busy: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

    // R11: a deselect lasts more than a single clock
    a_r11_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);

    // R5: read completion is a single pulse
    a_r5_rd_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

endmodule

// File: rtl/fram_host_regs.sv
module fram_host_regs
    import fram_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0310
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [15:0]        hst_addr,
    input  logic [7:0]         hst_wdata,
    output logic               hst_ready,
    output logic [7:0]         hst_rdata,
    input  logic               lock_top,
    input  logic               seq_busy,
    input  logic               rd_done,
    input  logic [FRAM_DW-1:0] rd_byte,
    output logic               cmd_vld,
    output fram_cmd_t          cmd
);

    typedef enum logic {H_IDLE, H_WAITRD} host_st_e;

    host_st_e           hst;
    logic [FRAM_AW-1:0] addr_q;
    logic [FRAM_DW-1:0] data_q;
    logic               burst_q;
    logic               ready_q;
    logic [7:0]         rdata_q;
    logic               hit;
    logic               take;
    logic               busy;
    logic [7:0]         status;
    reg_off_e           off;

    assign hit       = (hst_addr[15:2] == BASE_ADDR[15:2]);
    assign off       = reg_off_e'(hst_addr[1:0]);
    assign take      = hst_req && hit && !ready_q && (hst == H_IDLE);
    assign busy      = seq_busy || cmd_vld || (hst == H_WAITRD);
    assign status    = {busy, lock_top, 5'b0, burst_q};
    assign hst_ready = ready_q;
    assign hst_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hst     <= H_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            burst_q <= 1'b0;
            ready_q <= 1'b0;
            rdata_q <= '0;
            cmd_vld <= 1'b0;
            cmd     <= '0;
        end else begin
            ready_q <= 1'b0;
            cmd_vld <= 1'b0;
            if (take) begin
                case (off)
                    OFF_ALO: begin
                        if (hst_we) begin
                            if (!busy) addr_q[7:0] <= hst_wdata;
                        end else begin
                            rdata_q <= addr_q[7:0];
                        end
                        ready_q <= 1'b1;
                    end
                    OFF_AHI: begin
                        if (hst_we) begin
                            if (!busy) addr_q[14:8] <= hst_wdata[6:0];
                        end else begin
                            rdata_q <= {1'b0, addr_q[14:8]};
                        end
                        ready_q <= 1'b1;
                    end
                    OFF_CTRL: begin
                        if (hst_we) burst_q <= hst_wdata[0];
                        else        rdata_q <= status;
                        ready_q <= 1'b1;
                    end
                    default: begin
                        if (!busy) begin
                            if (hst_we) begin
                                if (!(lock_top && in_locked_kb(addr_q))) begin
                                    data_q  <= hst_wdata;
                                    cmd_vld <= 1'b1;
                                    cmd     <= '{write: 1'b1, addr: addr_q, data: hst_wdata};
                                end
                                ready_q <= 1'b1;
                            end else begin
                                cmd_vld <= 1'b1;
                                cmd     <= '{write: 1'b0, addr: addr_q, data: data_q};
                                hst     <= H_WAITRD;
                            end
                            if (burst_q) addr_q <= addr_q + FRAM_AW'(1);
                        end
                    end
                endcase
            end else if (hst == H_WAITRD && rd_done) begin
                data_q  <= rd_byte;
                rdata_q <= rd_byte;
                ready_q <= 1'b1;
                hst     <= H_IDLE;
            end
        end
    end

    // R2: every completion is a one-cycle pulse
    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        hst_ready |=> !hst_ready);

    // R7: the address is frozen while a transaction is pending
    a_r7_addr_hold_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    // R9: no write command is issued into the locked kilobyte
    a_r9_locked_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd.write) |-> !($past(lock_top) && in_locked_kb(cmd.addr)));

endmodule

// File: rtl/fram_host_ctrl.sv
module fram_host_ctrl
    import fram_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0310,
    parameter int          SCK_DIV   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hst_req,
    input  logic        hst_we,
    input  logic [15:0] hst_addr,
    input  logic [7:0]  hst_wdata,
    output logic        hst_ready,
    output logic [7:0]  hst_rdata,
    input  logic        lock_top,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    logic               cmd_vld;
    fram_cmd_t          cmd;
    logic               seq_busy;
    logic               rd_done;
    logic [FRAM_DW-1:0] rd_byte;
    logic               byte_start;
    logic [7:0]         byte_tx;
    logic               byte_done;
    logic [7:0]         byte_rx;

    fram_host_regs #(.BASE_ADDR(BASE_ADDR)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .hst_req   (hst_req),
        .hst_we    (hst_we),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_ready (hst_ready),
        .hst_rdata (hst_rdata),
        .lock_top  (lock_top),
        .seq_busy  (seq_busy),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte),
        .cmd_vld   (cmd_vld),
        .cmd       (cmd)
    );

    fram_spi_seq #(.SCK_DIV(SCK_DIV)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_vld    (cmd_vld),
        .cmd        (cmd),
        .busy       (seq_busy),
        .rd_done    (rd_done),
        .rd_byte    (rd_byte),
        .spi_cs_n   (spi_cs_n),
        .byte_start (byte_start),
        .byte_tx    (byte_tx),
        .byte_done  (byte_done),
        .byte_rx    (byte_rx)
    );

    fram_spi_byte #(.SCK_DIV(SCK_DIV)) i_shift (
        .clk   (clk),
        .rst   (rst),
        .start (byte_start),
        .tx    (byte_tx),
        .done  (byte_done),
        .rx    (byte_rx),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .miso  (spi_miso)
    );

    // R11: mode 0, clock low whenever the memory is deselected
    a_r11_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/test_fram_host_ctrl.sv
module test_fram_host_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          SCK_DIV    = 4;
    localparam logic [15:0] BASE       = 16'h0310;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [15:0] hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic        hst_ready;
    logic [7:0]  hst_rdata;
    logic        lock_top = 1'b0;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fram_host_ctrl #(.BASE_ADDR(BASE), .SCK_DIV(SCK_DIV)) i_fram_host_ctrl (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_ready(hst_ready),
        .hst_rdata(hst_rdata), .lock_top(lock_top), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] init_byte(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    // ---------------- behavioural serial memory ----------------
    logic [7:0] mem [int];
    int         bitn = 0;
    logic [7:0] sh = '0, op = '0, rbyte = '0;
    logic [14:0] maddr = '0;
    bit         wel = 0;
    int         frames = 0, frame_err = 0, addr_err = 0, nowel_err = 0;
    int         sck_err = 0, gap_err = 0, cyc = 0, last_rise = 0, cs_rise = 0;
    bit         seen_frame = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        if (seen_frame && (cyc - cs_rise) < SCK_DIV) gap_err++;
        bitn = 0;
        frames++;
    end

    always @(posedge spi_cs_n) begin
        seen_frame = 1;
        cs_rise = cyc;
        if (bitn % 8 != 0) frame_err++;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (bitn > 0 && (cyc - last_rise) != SCK_DIV) sck_err++;
            last_rise = cyc;
            sh = {sh[6:0], spi_mosi};
            bitn++;
            if (bitn % 8 == 0) begin
                case (bitn / 8)
                    1: begin op = sh; if (op == 8'h06) wel = 1; end
                    2: begin maddr[14:8] = sh[6:0]; if (sh[7]) addr_err++; end
                    3: begin
                        maddr[7:0] = sh;
                        rbyte = mem.exists(int'(maddr)) ? mem[int'(maddr)] : init_byte(maddr);
                    end
                    4: if (op == 8'h02) begin
                        if (!wel) nowel_err++;
                        else mem[int'(maddr)] = sh;
                        wel = 0;
                    end
                    default: ;
                endcase
            end
            if (op == 8'h03 && bitn >= 24 && bitn < 32) spi_miso = rbyte[31 - bitn];
        end
    end

    // ---------------- expected model ----------------
    logic [7:0]  exp_mem [int];
    logic [14:0] exp_addr = '0;
    bit          exp_burst = 0;

    function automatic logic [7:0] exp_rd(logic [14:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(a);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic host_io(input bit we, input logic [15:0] a, input logic [7:0] wd,
                           output logic [7:0] rd);
        int t;
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = wd;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!hst_ready && t < 2000);
        if (!hst_ready) chk("R2 host timeout", 0, 1);
        rd = hst_rdata;
        hst_req = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] off, input logic [7:0] v);
        logic [7:0] d;
        host_io(1'b1, BASE + 16'(off), v, d);
    endtask

    task automatic reg_rd(input logic [1:0] off, output logic [7:0] v);
        host_io(1'b0, BASE + 16'(off), 8'h00, v);
    endtask

    task automatic wait_idle;
        logic [7:0] s;
        int k;
        k = 0;
        do begin
            reg_rd(2'd3, s);
            k++;
        end while (s[7] && k < 500);
    endtask

    task automatic set_addr(input logic [14:0] a);
        wait_idle();
        reg_wr(2'd0, a[7:0]);
        reg_wr(2'd1, {1'b0, a[14:8]});
        exp_addr = a;
    endtask

    task automatic data_wr(input logic [7:0] v);
        reg_wr(2'd2, v);
        if (!(lock_top && exp_addr >= 15'h7C00)) exp_mem[int'(exp_addr)] = v;
        if (exp_burst) exp_addr = exp_addr + 15'd1;
    endtask

    task automatic data_rd(input string tag);
        logic [7:0] v, e;
        e = exp_rd(exp_addr);
        reg_rd(2'd2, v);
        chk(tag, v, e);
        if (exp_burst) exp_addr = exp_addr + 15'd1;
    endtask

    task automatic chk_addr(input string tag);
        logic [7:0] lo, hi;
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        chk(tag, {hi, lo}, {1'b0, exp_addr});
    endtask

    task automatic set_burst(input bit b);
        reg_wr(2'd3, {7'd0, b});
        exp_burst = b;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        chk("watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int f0, t;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int i = 0; i < 4; i++) begin
            if (i == 2) continue;
            reg_rd(2'(i), v);
            chk($sformatf("R1 reset offset %0d", i), v, 8'h00);
        end

        // R3 top address bit not stored
        reg_wr(2'd1, 8'hFF);
        reg_rd(2'd1, v);
        chk("R3 addr high bit7", v, 8'h7F);

        // R10 only burst bit writable
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd3, v);
        chk("R10 ctrl readback", v, 8'h01);
        set_burst(0);

        // R4 single write, R6 busy seen, R7 ignored address write
        set_addr(15'h0144);
        data_wr(8'h32);
        reg_rd(2'd3, v);
        chk("R6 busy after posted write", v[7], 1'b1);
        reg_wr(2'd0, 8'h55);
        reg_wr(2'd1, 8'h12);
        wait_idle();
        chk_addr("R7 address write while busy ignored");
        chk("R4 memory got byte", mem.exists(32'h144) ? mem[32'h144] : 8'hxx, 8'h32);
        data_rd("R5 read back 0x144");

        // R6 back-to-back data writes stall and keep order
        set_addr(15'h0200);
        set_burst(1);
        data_wr(8'hA1);
        data_wr(8'hB2);
        data_wr(8'hC3);
        set_burst(0);
        set_addr(15'h0201);
        data_rd("R6 queued second write");
        set_addr(15'h0202);
        data_rd("R6 queued third write");

        // R8 burst wrap
        set_addr(15'h7FFE);
        set_burst(1);
        data_wr(8'h11);
        data_wr(8'h22);
        data_wr(8'h33);
        chk_addr("R8 address wrapped");
        set_burst(0);
        set_addr(15'h7FFE);
        data_rd("R8 byte at 7FFE");
        set_addr(15'h0000);
        data_rd("R8 byte at 0000");
        chk_addr("R8 no increment without burst");

        // R9 lock
        lock_top = 1'b1;
        reg_rd(2'd3, v);
        chk("R9 lock bit in status", v, 8'h40);
        set_addr(15'h7C00);
        wait_idle();
        f0 = frames;
        data_wr(8'h99);
        wait_idle();
        chk("R9 no frame for locked write", frames, f0);
        data_rd("R9 locked byte unchanged");
        set_addr(15'h7BFF);
        f0 = frames;
        data_wr(8'h77);
        wait_idle();
        chk("R9 write below boundary frames", frames, f0 + 2);
        data_rd("R9 write below boundary data");
        set_addr(15'h7FFF);
        set_burst(1);
        data_wr(8'h5C);
        chk_addr("R9 locked write still increments");
        set_burst(0);
        lock_top = 1'b0;

        // R2 out-of-window access
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b1; hst_addr = BASE + 16'd4; hst_wdata = 8'hEE;
        t = 0;
        repeat (30) begin
            @(negedge clk);
            if (hst_ready) t++;
        end
        hst_req = 1'b0;
        chk("R2 no ready outside window", t, 0);
        chk_addr("R2 outside write changed nothing");

        // random mix
        for (int i = 0; i < 60; i++) begin
            int sel;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: set_addr(15'($urandom_range(0, 32767)));
                1: set_burst(1'($urandom_range(0, 1)));
                2: lock_top = 1'($urandom_range(0, 1));
                3, 4: data_wr(8'($urandom_range(0, 255)));
                default: data_rd("R5 random read");
            endcase
        end
        wait_idle();
        chk_addr("R8 random address track");
        lock_top = 1'b0;
        set_burst(0);
        set_addr(15'h7C10);
        data_rd("R9 random window read");

        wait_idle();
        chk("R4 write without enable", nowel_err, 0);
        chk("R4 address top bit", addr_err, 0);
        chk("R11 partial byte frames", frame_err, 0);
        chk("R11 sck spacing", sck_err, 0);
        chk("R11 cs gap", gap_err, 0);

        report();
        $finish;
    end

endmodule